// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a one-byte SPI master that a CPU drives through three 8-bit registers on a simple register bus: control, status and data. Each bus write takes effect on a rising clock edge. Reads are combinational from the address. Software first sets the mode, bit order and clock rate in the control register. A write to the data register then launches one full-duplex byte exchange on `sck`, `mosi` and `miso`.

The SPI clock comes from a prescaler on the system clock. The divisor is 2 to 128, set by a two-bit rate code and a double-speed bit. When the eighth bit has been sampled, the received byte lands in the data register and a completion flag rises. That flag requests an interrupt if interrupts are enabled. A data write made while a byte is still moving is refused and sets a collision flag. Chip select is left to the system. The master-select control bit is stored and read back but changes nothing.

Register addresses on `bus_addr`: 0 is control, 1 is status, 2 is data.

Top module: `spi_byte_ctrl`

## Requirements
- R1: A synchronous reset clears all registers and flags. After reset every register reads 0, `irq` is 0, `sck` is 0 and `mosi` is 0.
- R2: The control register reads back exactly what was written. Its bits are: bit7 interrupt enable, bit6 enable, bit5 LSB-first, bit4 master select (stored only), bit3 clock polarity, bit2 clock phase, bits1:0 rate code. The status register reads {done, collision, 5'b0, double-speed}.
- R3: A data write made while the enable bit is 0 is ignored. No SCK edge occurs and the status register stays unchanged.
- R4: A data write made while a transfer is running sets the collision flag (status bit6). It changes neither the byte being sent nor the length of the transfer.
- R5: An accepted data write clears the collision flag and the done flag, then starts the transfer.
- R6: The divisor D is a base of 2 when double-speed is set, 4 otherwise. The base is multiplied by 1, 4, 16 or 32 for rate codes 00, 01, 10 and 11. The done flag rises exactly 8·D clock cycles after the accepting write edge.
- R7: At completion, the byte sampled from `miso` becomes readable in the data register and the done flag (status bit7) is set.
- R8: `irq` is 1 exactly while the done flag and the interrupt-enable bit are both 1.
- R9: With the LSB-first bit set, bits go out and come in least-significant first. Otherwise they go most-significant first.
- R10: Between transfers, `sck` rests at the polarity bit. With phase 0, data is sampled on the leading SCK edge; with phase 1, on the trailing edge. Each SCK half period lasts D/2 clocks.
- R11: A status write with bit7 set clears the done flag. Status bit0 of any status write sets the double-speed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Completion interrupt request |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a collision write that arrives partway through a transfer. The stimulus must show that this write leaves the outgoing bit stream and the completion time untouched. To reach it, the bench runs the fastest divisor and injects a second data write a few cycles after the accepted one. A bench-side SPI slave, driven only by `sck` edges, captures the bits on `mosi` and supplies the bits on `miso`. Its captured byte is compared against the original byte queued by the driver, in all four clock modes and both bit orders.

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [7:0] ctrl_q, data_q, tx_q, rx_q;
  logic       dbl_q, done_q, wcol_q, busy_q;
  logic [6:0] hcnt_q, lim_q;
  logic [3:0] half_q;
  logic [2:0] rsh;
  logic [6:0] half_lim;

  wire ie   = ctrl_q[7];
  wire en   = ctrl_q[6];
  wire lsbf = ctrl_q[5];
  wire cpol = ctrl_q[3];
  wire cpha = ctrl_q[2];

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_data = bus_we && bus_addr == A_DATA;
  wire start   = wr_data && en && !busy_q;
  wire coll    = wr_data && en && busy_q;

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   rsh = 3'd0;
      2'b01:   rsh = 3'd2;
      2'b10:   rsh = 3'd4;
      default: rsh = 3'd5;
    endcase
  end
  assign half_lim = ((dbl_q ? 7'd1 : 7'd2) << rsh) - 7'd1;

  wire [2:0] bit_idx  = half_q[3:1];
  wire [2:0] bit_pos  = lsbf ? bit_idx : 3'd7 - bit_idx;
  wire       half_end = busy_q && hcnt_q == lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; data_q <= '0; tx_q <= '0; rx_q <= '0;
      dbl_q <= 1'b0; done_q <= 1'b0; wcol_q <= 1'b0; busy_q <= 1'b0;
      hcnt_q <= '0; lim_q <= '0; half_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_stat) begin
        dbl_q <= bus_wdata[0];
        if (bus_wdata[7]) done_q <= 1'b0;
      end
      if (coll) wcol_q <= 1'b1;
      if (start) begin
        wcol_q <= 1'b0;
        done_q <= 1'b0;
        busy_q <= 1'b1;
        tx_q   <= bus_wdata;
        hcnt_q <= '0;
        half_q <= '0;
        lim_q  <= half_lim;
      end else if (busy_q) begin
        if (half_end) begin
          hcnt_q <= '0;
          half_q <= half_q + 4'd1;
          if (!half_q[0]) rx_q[bit_pos] <= miso;
          if (half_q == 4'd15) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            data_q <= rx_q;
          end
        end else begin
          hcnt_q <= hcnt_q + 7'd1;
        end
      end
    end
  end

  assign sck  = busy_q ? (cpol ^ cpha ^ half_q[0]) : cpol;
  assign mosi = busy_q ? tx_q[bit_pos] : 1'b0;
  assign irq  = done_q & ie;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {done_q, wcol_q, 5'b0, dbl_q};
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module spi_byte_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] ctrl_q,
  input logic       dbl_q,
  input logic       busy_q,
  input logic       done_q,
  input logic       wcol_q,
  input logic [7:0] tx_q,
  input logic       sck
);
  logic [10:0] cnt_q, len_q;
  logic        prev_q;
  logic [10:0] len_now;

  always_comb begin
    len_now = dbl_q ? 11'd16 : 11'd32;
    case (ctrl_q[1:0])
      2'b00:   len_now = len_now;
      2'b01:   len_now = len_now * 11'd4;
      2'b10:   len_now = len_now * 11'd16;
      default: len_now = len_now * 11'd32;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; len_q <= '0; prev_q <= 1'b0;
    end else begin
      prev_q <= busy_q;
      if (busy_q && !prev_q) begin
        cnt_q <= 11'd1;
        len_q <= len_now;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 11'd1;
      end
    end
  end

  wire dwr = bus_we && bus_addr == 2'd2;

  assert_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> cnt_q == len_q);
  assert_collision_R4: assert property (@(posedge clk) disable iff (rst)
    (dwr && ctrl_q[6] && busy_q) |=> (wcol_q && tx_q == $past(tx_q)));
  assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (dwr && !ctrl_q[6] && !busy_q) |=> !busy_q);
  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (dwr && ctrl_q[6] && !busy_q) |=> (busy_q && !wcol_q && !done_q));
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> sck == ctrl_q[3]);
  assert_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
endmodule

bind spi_byte_ctrl spi_byte_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .ctrl_q(ctrl_q), .dbl_q(dbl_q), .busy_q(busy_q), .done_q(done_q),
  .wcol_q(wcol_q), .tx_q(tx_q), .sck(sck)
);

// File: tb/spi_byte_ctrl_tb_top.sv
module spi_byte_ctrl_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, sck, mosi;
  logic miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  int sck_changes = 0;
  byte unsigned q_mosi[$];
  logic s_cpha = 0, s_dord = 0, c_cpol = 0, c_ie = 0;
  logic c_dbl = 0;
  logic [1:0] c_rate = 0;
  logic [7:0] s_byte = 0;
  event go;

  always #2 clk = ~clk;

  spi_byte_ctrl dut_i (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso));

  always @(sck) sck_changes++;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic bitof(input logic [7:0] b, input int j, input logic lsb);
    return lsb ? b[j] : b[7-j];
  endfunction

  // SPI slave model and monitor
  always begin
    logic [7:0] cap;
    int j;
    byte unsigned exp;
    @(go);
    cap = '0; j = 0;
    if (!s_cpha) miso = bitof(s_byte, 0, s_dord);
    for (int e = 0; e < 16; e++) begin
      @(sck);
      if (!s_cpha) begin
        if (e % 2 == 0) begin
          if (s_dord) cap[j] = mosi; else cap[7-j] = mosi;
          j++;
        end else if (j < 8) miso = bitof(s_byte, j, s_dord);
      end else begin
        if (e % 2 == 0) miso = bitof(s_byte, j, s_dord);
        else begin
          if (s_dord) cap[j] = mosi; else cap[7-j] = mosi;
          j++;
        end
      end
    end
    exp = q_mosi.pop_front();
    chk(cap == exp, "R9 mosi byte order", cap, exp);
  end

  task automatic cfg(input logic ie, en, dord, ms, cpol, cpha, input logic [1:0] rate, input logic dbl);
    logic [7:0] v;
    v = {ie, en, dord, ms, cpol, cpha, rate};
    wr(2'd0, v);
    wr(2'd1, {7'b0, dbl});
    c_ie = ie; c_cpol = cpol; c_rate = rate; c_dbl = dbl;
    s_cpha = cpha; s_dord = dord;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input int coll);
    int d;
    logic [7:0] r;
    d = (c_dbl ? 2 : 4) * (c_rate == 0 ? 1 : c_rate == 1 ? 4 : c_rate == 2 ? 16 : 32);
    #1 chk(sck == c_cpol, "R10 idle sck", sck, c_cpol);
    q_mosi.push_back(tx);
    s_byte = sb;
    ->go;
    @(negedge clk); bus_addr = 2'd2; bus_wdata = tx; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(2'd1, r);
    chk(r[7:6] == 2'b00, "R5 flags cleared on start", r, 0);
    for (int i = 1; i < 8*d; i++) begin
      @(negedge clk); bus_we = 1'b0; bus_addr = 2'd1;
      if (i == coll) begin bus_addr = 2'd2; bus_wdata = ~tx; bus_we = 1'b1; end
    end
    bus_we = 1'b0;
    rd(2'd1, r);
    chk(r[7] == 1'b0, "R6 done not before 8*D", r, 0);
    chk(r[6] == (coll > 0), "R4 collision flag", r[6], coll > 0);
    @(negedge clk);
    rd(2'd1, r);
    chk(r[7] == 1'b1, "R6 done at 8*D", r, 8'h80);
    chk(irq == c_ie, "R8 irq", irq, c_ie);
    chk(sck == c_cpol, "R10 sck back idle", sck, c_cpol);
    rd(2'd2, r);
    chk(r == sb, "R7 received byte", r, sb);
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int sc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, r); chk(r == 0, "R1 ctrl reset", r, 0);
    rd(2'd1, r); chk(r == 0, "R1 status reset", r, 0);
    rd(2'd2, r); chk(r == 0, "R1 data reset", r, 0);
    chk({irq, sck, mosi} == 3'b000, "R1 outputs reset", {irq, sck, mosi}, 0);

    wr(2'd0, 8'h9A);
    rd(2'd0, r); chk(r == 8'h9A, "R2 ctrl readback", r, 8'h9A);
    cfg(1, 0, 0, 1, 0, 0, 2'd0, 0);
    sc = sck_changes;
    wr(2'd2, 8'hC3);
    repeat (40) @(negedge clk);
    chk(sck_changes == sc, "R3 no sck when disabled", sck_changes - sc, 0);
    rd(2'd1, r); chk(r == 0, "R3 status untouched", r, 0);

    cfg(1, 1, 0, 1, 0, 0, 2'd0, 0);
    xfer(8'hA5, 8'h3C, 0);
    wr(2'd1, 8'h81);
    rd(2'd1, r); chk(r == 8'h01, "R11 done cleared, double-speed set", r, 8'h01);
    chk(irq == 1'b0, "R8 irq drops with done", irq, 0);

    cfg(1, 1, 1, 1, 0, 1, 2'd1, 1);
    xfer(8'h1E, 8'hD2, 0);
    cfg(1, 1, 0, 1, 1, 0, 2'd2, 0);
    xfer(8'h96, 8'h41, 0);
    cfg(0, 1, 1, 1, 1, 1, 2'd3, 0);
    xfer(8'h6B, 8'hF0, 0);
    cfg(1, 1, 0, 1, 0, 1, 2'd0, 1);
    xfer(8'hC7, 8'h58, 3);
    xfer(8'h0F, 8'hE1, 0);
    cfg(1, 1, 1, 1, 1, 0, 2'd0, 1);
    xfer(8'h81, 8'h7E, 5);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule